// File: doc/BRIEF.md
# Dual-Edge Input Capture Timer

This block timestamps the edges of two external signals against a 16-bit counter that runs freely on the block clock. Every input has two capture registers: one takes the counter on a rising edge and the other on a falling edge. Software can measure a pulse width or a period by subtracting two captured values. Each input pin passes through a two-flop synchronizer. A small per-input state machine then follows the synchronized level and reports each edge.

A control register enables each edge of each input on its own. A mode bit combines the two channels into one wide channel. In that wide mode, input 1 is ignored. Its two registers then hold the upper counter byte of the captures on input 0, so that input 0 records full 16-bit times. A sticky status bit records every capture and drives a level interrupt. Two pulse interrupts mark a counter wrap and a fixed tick period, which is 51200 clocks (1024 µs at 50 MHz) by default.

The edge state machine has two states. ST_LOW moves to ST_HIGH on a synchronized 1, and that transition is the rise event. ST_HIGH moves to ST_LOW on a synchronized 0, and that transition is the fall event. When no transition occurs, the state holds.

Top module: `dual_edge_capture_timer`

Register map (3-bit address, 8-bit data, read data is combinational on the address):

| Address | Access | Contents |
|---|---|---|
| 0 | read | counter bits 7:0 |
| 1 | read | counter bits 15:8 |
| 2 | read | input 0 rise capture (wide: rise bits 7:0) |
| 3 | read | input 1 rise capture (wide: input 0 rise bits 15:8) |
| 4 | read | input 0 fall capture (wide: fall bits 7:0) |
| 5 | read | input 1 fall capture (wide: input 0 fall bits 15:8) |
| 6 | read/write | control |
| 7 | read / write-1-to-clear | status |

Bit layout of both the control register and the status register:

| Bit | Meaning |
|---|---|
| 0 | input 0 rise |
| 1 | input 0 fall |
| 2 | input 1 rise |
| 3 | input 1 fall |
| 7 | control only: wide mode |

Control bits 6:4 always read 0.

## Requirements
- R1: After reset the counter is 0. It then increments by one every clock and wraps from 16'hFFFF to 0. Address 0 reads its low byte and address 1 reads its high byte.
- R2: For a pulse that is high for W clocks, the fall capture minus the rise capture equals W. In 8-bit mode the difference is taken modulo 256, and in wide mode modulo 65536.
- R3: In 8-bit mode each capture register stores counter bits 7:0. Channel 1 captures into addresses 3 and 5 and leaves the channel 0 registers at addresses 2 and 4 unchanged.
- R4: A capture and its status bit occur only when the control enable bit for that edge is 1. A disabled edge leaves both its capture register and its status bit unchanged.
- R5: With control bit 7 set, an enabled edge on input 0 stores counter bits 7:0 at address 2 or 4 and bits 15:8 at address 3 or 5. Pulses on input 1 change no register and set no status bit.
- R6: A status bit is set by its capture and stays set until a write of 1 to that bit at address 7. Writing 0 to a bit has no effect. A capture in the same cycle as a clear leaves the bit set.
- R7: irq_capture is high exactly while any status bit is set.
- R8: irq_wrap is high for one cycle, during the cycle in which the counter reads 0 after holding 16'hFFFF.
- R9: irq_tick pulses for one cycle every TICK_CYCLES clocks, 51200 by default.
- R10: After reset, all capture registers, the control register and the status register read 0, and irq_capture is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block and capture clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cap_in | input | 2 | Asynchronous capture inputs, bit n is input n |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register address |
| wdata | input | 8 | Register write data |
| rdata | output | 8 | Register read data at addr |
| irq_capture | output | 1 | Level interrupt, any status bit set |
| irq_wrap | output | 1 | One-cycle pulse on counter wrap |
| irq_tick | output | 1 | One-cycle periodic tick |

## Verification
The assertions check four properties on every cycle:
- the counter advances by exactly one per clock;
- status bits never drop without a status write;
- input 1 can set no status bit while wide mode is on;
- the wrap and tick interrupts are single-cycle pulses, and the wrap pulse coincides with a zero count.

Only the bench scenarios can show the following, because they depend on the captured values and the pulse widths being driven:
- that the difference between captures matches the driven pulse width in both modes;
- that a disabled edge leaves its register untouched;
- that a capture wins over a same-cycle clear;
- that the tick period has its exact length.

// File: rtl/cap_pkg.sv
package cap_pkg;

    localparam int CNT_W   = 16;
    localparam int BYTE_W  = 8;
    localparam int NUM_CH  = 2;
    localparam int NUM_EV  = 2 * NUM_CH;
    localparam int ADDR_W  = 3;

    localparam logic [ADDR_W-1:0] A_CNT_LO  = 3'd0;
    localparam logic [ADDR_W-1:0] A_CNT_HI  = 3'd1;
    localparam logic [ADDR_W-1:0] A_RISE0   = 3'd2;
    localparam logic [ADDR_W-1:0] A_RISE1   = 3'd3;
    localparam logic [ADDR_W-1:0] A_FALL0   = 3'd4;
    localparam logic [ADDR_W-1:0] A_FALL1   = 3'd5;
    localparam logic [ADDR_W-1:0] A_CTRL    = 3'd6;
    localparam logic [ADDR_W-1:0] A_STATUS  = 3'd7;

    localparam int WIDE_BIT = 7;
    localparam logic [BYTE_W-1:0] CTRL_MASK = 8'h8F;

    typedef enum logic {
        ST_LOW  = 1'b0,
        ST_HIGH = 1'b1
    } edge_state_t;

endpackage

// File: rtl/cap_edge_fsm.sv
module cap_edge_fsm
    import cap_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    output logic rise_evt,
    output logic fall_evt
);

    logic        sync1_q;
    logic        sync2_q;
    edge_state_t state_q;
    edge_state_t state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync1_q <= 1'b0;
            sync2_q <= 1'b0;
        end else begin
            sync1_q <= pin;
            sync2_q <= sync1_q;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_LOW:  if (sync2_q)  state_d = ST_HIGH;
            ST_HIGH: if (!sync2_q) state_d = ST_LOW;
            default: state_d = ST_LOW;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_LOW;
        else        state_q <= state_d;
    end

    always_comb begin
        rise_evt = 1'b0;
        fall_evt = 1'b0;
        unique case (state_q)
            ST_LOW:  rise_evt = sync2_q;
            ST_HIGH: fall_evt = !sync2_q;
            default: ;
        endcase
    end

endmodule

// File: rtl/cap_timebase.sv
module cap_timebase #(
    parameter int CNT_W       = 16,
    parameter int TICK_CYCLES = 51200
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic [CNT_W-1:0] cnt,
    output logic             wrap_pulse,
    output logic             tick_pulse
);

    localparam int TICK_W = (TICK_CYCLES > 1) ? $clog2(TICK_CYCLES) : 1;
    localparam logic [TICK_W-1:0] TICK_LAST = TICK_W'(TICK_CYCLES - 1);
    localparam logic [CNT_W-1:0]  CNT_MAX   = {CNT_W{1'b1}};

    logic [TICK_W-1:0] tick_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt        <= '0;
            wrap_pulse <= 1'b0;
        end else begin
            cnt        <= cnt + 1'b1;
            wrap_pulse <= (cnt == CNT_MAX);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tick_q     <= '0;
            tick_pulse <= 1'b0;
        end else if (tick_q == TICK_LAST) begin
            tick_q     <= '0;
            tick_pulse <= 1'b1;
        end else begin
            tick_q     <= tick_q + 1'b1;
            tick_pulse <= 1'b0;
        end
    end

endmodule

// File: rtl/cap_capture_bank.sv
module cap_capture_bank #(
    parameter int NUM_CH = 2,
    parameter int BYTE_W = 8,
    parameter int CNT_W  = 16
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [CNT_W-1:0]           cnt,
    input  logic [2*NUM_CH-1:0]        evt,
    input  logic [2*NUM_CH-1:0]        edge_en,
    input  logic                       wide,
    input  logic [2*NUM_CH-1:0]        clr,
    output logic [2*NUM_CH*BYTE_W-1:0] cap_bytes,
    output logic [2*NUM_CH-1:0]        status
);

    localparam int NUM_EV = 2 * NUM_CH;

    logic [NUM_EV-1:0] take;

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        for (genvar e = 0; e < 2; e++) begin : g_edge
            localparam int IDX = 2 * c + e;
            logic [BYTE_W-1:0] cap_q;

            if (c == 0) begin : g_base
                assign take[IDX] = evt[IDX] && edge_en[IDX];
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n)         cap_q <= '0;
                    else if (take[IDX]) cap_q <= cnt[BYTE_W-1:0];
                end
            end else if (c == 1) begin : g_ext
                assign take[IDX] = evt[IDX] && edge_en[IDX] && !wide;
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n)                 cap_q <= '0;
                    else if (wide && take[e])   cap_q <= cnt[CNT_W-1:CNT_W-BYTE_W];
                    else if (take[IDX])         cap_q <= cnt[BYTE_W-1:0];
                end
            end else begin : g_more
                assign take[IDX] = evt[IDX] && edge_en[IDX];
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n)         cap_q <= '0;
                    else if (take[IDX]) cap_q <= cnt[BYTE_W-1:0];
                end
            end

            assign cap_bytes[IDX*BYTE_W +: BYTE_W] = cap_q;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) status <= '0;
        else        status <= (status & ~clr) | take;
    end

endmodule

// File: rtl/dual_edge_capture_timer.sv
module dual_edge_capture_timer
    import cap_pkg::*;
#(
    parameter int TICK_CYCLES = 51200
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] cap_in,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [BYTE_W-1:0] wdata,
    output logic [BYTE_W-1:0] rdata,
    output logic              irq_capture,
    output logic              irq_wrap,
    output logic              irq_tick
);

    logic [CNT_W-1:0]         cnt_q;
    logic [NUM_EV-1:0]        evt;
    logic [NUM_EV-1:0]        status_q;
    logic [NUM_EV-1:0]        clr;
    logic [BYTE_W-1:0]        ctrl_q;
    logic [NUM_EV*BYTE_W-1:0] cap_bytes;

    cap_timebase #(.CNT_W(CNT_W), .TICK_CYCLES(TICK_CYCLES)) u_time (
        .clk        (clk),
        .rst_n      (rst_n),
        .cnt        (cnt_q),
        .wrap_pulse (irq_wrap),
        .tick_pulse (irq_tick)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_in
        cap_edge_fsm u_edge (
            .clk      (clk),
            .rst_n    (rst_n),
            .pin      (cap_in[c]),
            .rise_evt (evt[2*c]),
            .fall_evt (evt[2*c+1])
        );
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                        ctrl_q <= '0;
        else if (wr_en && addr == A_CTRL)  ctrl_q <= wdata & CTRL_MASK;
    end

    assign clr = (wr_en && addr == A_STATUS) ? wdata[NUM_EV-1:0] : '0;

    cap_capture_bank #(.NUM_CH(NUM_CH), .BYTE_W(BYTE_W), .CNT_W(CNT_W)) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .cnt       (cnt_q),
        .evt       (evt),
        .edge_en   (ctrl_q[NUM_EV-1:0]),
        .wide      (ctrl_q[WIDE_BIT]),
        .clr       (clr),
        .cap_bytes (cap_bytes),
        .status    (status_q)
    );

    always_comb begin
        unique case (addr)
            A_CNT_LO: rdata = cnt_q[BYTE_W-1:0];
            A_CNT_HI: rdata = cnt_q[CNT_W-1:CNT_W-BYTE_W];
            A_RISE0:  rdata = cap_bytes[0*BYTE_W +: BYTE_W];
            A_RISE1:  rdata = cap_bytes[2*BYTE_W +: BYTE_W];
            A_FALL0:  rdata = cap_bytes[1*BYTE_W +: BYTE_W];
            A_FALL1:  rdata = cap_bytes[3*BYTE_W +: BYTE_W];
            A_CTRL:   rdata = ctrl_q;
            A_STATUS: rdata = {{(BYTE_W-NUM_EV){1'b0}}, status_q};
            default:  rdata = '0;
        endcase
    end

    assign irq_capture = |status_q;

endmodule

// File: rtl/cap_timer_checker.sv
module cap_timer_checker
    import cap_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [ADDR_W-1:0] addr,
    input logic              irq_wrap,
    input logic              irq_tick,
    input logic [NUM_EV-1:0] status_q,
    input logic [BYTE_W-1:0] ctrl_q,
    input logic [CNT_W-1:0]  cnt_q
);

    AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> cnt_q == CNT_W'($past(cnt_q) + 1'b1)); // R1

    AST_STATUS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && addr == A_STATUS) |=> ((status_q & $past(status_q)) == $past(status_q))); // R6

    AST_WIDE_CH1_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_q[WIDE_BIT] && status_q[3:2] == 2'b00 && !(wr_en && addr == A_CTRL))
        |=> status_q[3:2] == 2'b00); // R5

    AST_WRAP_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        irq_wrap |-> cnt_q == '0); // R8

    AST_WRAP_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        irq_wrap |=> !irq_wrap); // R8

    AST_TICK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        irq_tick |=> !irq_tick); // R9

endmodule

bind dual_edge_capture_timer cap_timer_checker u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .addr     (addr),
    .irq_wrap (irq_wrap),
    .irq_tick (irq_tick),
    .status_q (status_q),
    .ctrl_q   (ctrl_q),
    .cnt_q    (cnt_q)
);

// File: tb/tb_dual_edge_capture_timer.sv
`timescale 1ns/1ps
module tb_dual_edge_capture_timer;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] cap_in = 2'b00;
    logic       wr_en = 1'b0;
    logic [2:0] addr = 3'd0;
    logic [7:0] wdata = 8'd0;
    logic [7:0] rdata;
    logic       irq_capture, irq_wrap, irq_tick;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    dual_edge_capture_timer dut (
        .clk(clk), .rst_n(rst_n), .cap_in(cap_in), .wr_en(wr_en),
        .addr(addr), .wdata(wdata), .rdata(rdata),
        .irq_capture(irq_capture), .irq_wrap(irq_wrap), .irq_tick(irq_tick)
    );

    typedef struct packed {
        logic        wide;
        logic        ch;
        logic [15:0] width;
    } vec_t;

    localparam int NVEC = 7;
    localparam vec_t VECS [NVEC] = '{
        '{1'b0, 1'b0, 16'd5},
        '{1'b0, 1'b1, 16'd17},
        '{1'b0, 1'b0, 16'd1},
        '{1'b0, 1'b1, 16'd200},
        '{1'b1, 1'b0, 16'd300},
        '{1'b1, 1'b0, 16'd1000},
        '{1'b1, 1'b0, 16'd3}
    };

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] v);
        @(negedge clk); addr = a; #1 v = rdata;
    endtask

    task automatic pulse(input int ch, input int w);
        @(negedge clk); cap_in[ch] = 1'b1;
        repeat (w) @(negedge clk);
        cap_in[ch] = 1'b0;
        repeat (6) @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (190000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=1 expected=0");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin : main
        logic [7:0] v, rl, rh, fl, fh, s_before;
        int n;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R10: reset state
        for (int a = 2; a < 8; a++) begin
            rd(3'(a), v);
            chk(v == 8'd0, "R10 reset register", v, 0);
        end
        chk(irq_capture == 1'b0, "R10 irq_capture after reset", irq_capture, 0);

        // R1: counter increments by one per clock
        rd(3'd0, rl);
        @(negedge clk); #1 v = rdata;
        chk(v == 8'(rl + 1), "R1 counter step", v, 8'(rl + 1));

        // Vector table: pulse widths in both modes (R2, R3, R5, R7)
        for (int i = 0; i < NVEC; i++) begin
            wr(3'd6, VECS[i].wide ? 8'h83 : 8'h0F);
            wr(3'd7, 8'h0F);
            pulse(int'(VECS[i].ch), int'(VECS[i].width));
            if (VECS[i].wide) begin
                rd(3'd2, rl); rd(3'd3, rh); rd(3'd4, fl); rd(3'd5, fh);
                chk(16'({fh, fl} - {rh, rl}) == VECS[i].width, "R2 R5 wide width",
                    int'(16'({fh, fl} - {rh, rl})), int'(VECS[i].width));
                rd(3'd7, v);
                chk(v == 8'h03, "R5 wide status", v, 3);
            end else begin
                rd(VECS[i].ch ? 3'd3 : 3'd2, rl);
                rd(VECS[i].ch ? 3'd5 : 3'd4, fl);
                chk(8'(fl - rl) == 8'(VECS[i].width), "R2 R3 byte width",
                    int'(8'(fl - rl)), int'(8'(VECS[i].width)));
                rd(3'd7, v);
                chk(v == (VECS[i].ch ? 8'h0C : 8'h03), "R3 byte status", v,
                    VECS[i].ch ? 12 : 3);
            end
            chk(irq_capture == 1'b1, "R7 irq_capture set", irq_capture, 1);
        end

        // R3: channel 1 pulse leaves channel 0 registers unchanged
        wr(3'd6, 8'h0F);
        rd(3'd2, rl); rd(3'd4, fl);
        pulse(1, 9);
        rd(3'd2, rh); rd(3'd4, fh);
        chk(rh == rl && fh == fl, "R3 ch0 untouched by ch1", {rh, fh}, {rl, fl});

        // R5: input 1 ignored in wide mode
        wr(3'd6, 8'h83);
        wr(3'd7, 8'h0F);
        rd(3'd3, rl); rd(3'd5, fl);
        pulse(1, 11);
        rd(3'd3, rh); rd(3'd5, fh);
        chk(rh == rl && fh == fl, "R5 ch1 regs unchanged in wide", {rh, fh}, {rl, fl});
        rd(3'd7, v);
        chk(v == 8'h00, "R5 no status from ch1 in wide", v, 0);
        chk(irq_capture == 1'b0, "R7 irq_capture clear", irq_capture, 0);

        // R4: rise disabled, fall enabled on input 0
        wr(3'd6, 8'h02);
        rd(3'd2, rl);
        pulse(0, 7);
        rd(3'd2, rh);
        chk(rh == rl, "R4 disabled rise register", rh, rl);
        rd(3'd7, v);
        chk(v == 8'h02, "R4 only fall status", v, 2);

        // R6: capture in the same cycle as clear keeps the bit set
        wr(3'd6, 8'h0F);
        wr(3'd7, 8'h0F);
        @(negedge clk); cap_in[0] = 1'b1;
        @(posedge clk); @(negedge clk);
        @(posedge clk); @(negedge clk); wr_en = 1'b1; addr = 3'd7; wdata = 8'h01;
        @(posedge clk); @(negedge clk); wr_en = 1'b0;
        rd(3'd7, v);
        chk(v[0] == 1'b1, "R6 set wins over clear", v[0], 1);
        @(negedge clk); cap_in[0] = 1'b0;
        repeat (6) @(negedge clk);
        rd(3'd7, s_before);
        chk(s_before == 8'h03, "R6 sticky both bits", s_before, 3);
        wr(3'd7, 8'h00);
        rd(3'd7, v);
        chk(v == 8'h03, "R6 write zero no effect", v, 3);
        wr(3'd7, 8'h01);
        rd(3'd7, v);
        chk(v == 8'h02, "R6 write one clears", v, 2);

        // R9: tick period
        @(negedge clk);
        while (!irq_tick) @(negedge clk);
        @(negedge clk);
        chk(irq_tick == 1'b0, "R9 tick single cycle", irq_tick, 0);
        n = 1;
        while (!irq_tick) begin @(negedge clk); n++; end
        chk(n == 51200, "R9 tick period", n, 51200);

        // R8: wrap pulse with zero count
        addr = 3'd1;
        @(negedge clk);
        while (!irq_wrap) @(negedge clk);
        #1 rh = rdata;
        addr = 3'd0;
        #1 rl = rdata;
        chk({rh, rl} == 16'd0, "R8 count zero at wrap", {rh, rl}, 0);
        @(negedge clk); #1 v = rdata;
        chk(irq_wrap == 1'b0, "R8 wrap single cycle", irq_wrap, 0);
        chk(v == 8'd1, "R1 counter after wrap", v, 1);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule